// File: doc/BRIEF.md
# Idle and Stop Power-Mode Controller

This block sequences the low-power modes of a small 8-bit CPU core. Software enters a mode by writing the power-control register. A light mode holds the CPU and leaves every clock running. A deep mode gates every internal clock and shuts down the crystal oscillator amplifier. The block watches interrupt requests from clocked sources (timers, serial port, watchdog interrupt) and from non-clocked sources (external pins and a power-fail monitor). It also watches four reset sources: the external pin, the watchdog, a brownout detector and power-on. From these it decides when each mode ends and whether a reset request is honoured.

The wake and reset rules depend on the mode. In the light mode, any enabled interrupt and any reset source return the core to normal operation on the next cycle. In the deep mode, clocked sources cannot run, so only enabled non-clocked interrupts can wake the core. The power-fail interrupt counts only when the voltage reference is enabled. The external pin always resets the core. A brownout resets it only when the reference is enabled. A wake from the deep mode restarts the oscillator first. The CPU is released only after a fixed settle interval.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After power-on reset is released, `rst_out` is 1 for one cycle. The block then runs: `cpu_hold`=0, `periph_clk_en`=1, `core_clk_en`=1, `osc_en`=1 and `pwr_bits`=00.
- R2: In run, a write to address 87h with data bit 0 = 1 and bit 1 = 0 enters idle on the next cycle. Idle gives `cpu_hold`=1 with all clocks and the oscillator still enabled, and `pwr_bits`=01. A write to any other address has no effect.
- R3: In run, a write to address 87h with data bit 1 = 1 enters stop, even when bit 0 is also 1. Stop gives `cpu_hold`=1 with `periph_clk_en`, `core_clk_en` and `osc_en` all 0, and `pwr_bits` shows the written pair (10 or 11).
- R4: In idle, any enabled interrupt returns the block to run on the next cycle and clears `pwr_bits` to 00. An enabled interrupt here is a clocked request with its enable set, a non-clocked request with its enable set, or a power-fail request with `pf_en`. A request whose enable is 0 is ignored.
- R5: In stop, only an enabled non-clocked request, or a power-fail request with both `pf_en` and `ref_en` at 1, ends the mode. Clocked requests, disabled requests and a power-fail request with `ref_en`=0 leave the outputs unchanged.
- R6: In stop, the watchdog reset is ignored, and a brownout is ignored while `ref_en`=0. In both cases the block stays in stop with `rst_out`=0.
- R7: In run or idle, the external pin, the watchdog or a brownout causes a reset. In stop or settle, the external pin causes a reset, and so does a brownout when `ref_en`=1. A reset puts the block in run with `pwr_bits`=00 on the next cycle. `rst_out` rises one cycle after the source rises and falls one cycle after it falls, with no added delay.
- R8: A stop wake clears `pwr_bits` and raises `osc_en` on the next cycle. `cpu_hold` stays 1 and both clocks stay gated for exactly `SETTLE_CYC` cycles, and the block then returns to run.
- R9: Writes to the power-control register while the CPU is held (idle, stop or settle) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| pcon_wr | input | 1 | Register write strobe |
| pcon_addr | input | ADDR_W | Register write address |
| pcon_wdata | input | 2 | Written power bits: [1] stop, [0] idle |
| clk_irq_req | input | N_CLK_IRQ | Clocked interrupt requests |
| clk_irq_en | input | N_CLK_IRQ | Enables for the clocked requests |
| nc_irq_req | input | N_NC_IRQ | Non-clocked interrupt requests |
| nc_irq_en | input | N_NC_IRQ | Enables for the non-clocked requests |
| pf_req | input | 1 | Power-fail interrupt request |
| pf_en | input | 1 | Power-fail interrupt enable |
| ref_en | input | 1 | Voltage reference enable |
| ext_rst | input | 1 | External reset pin, active high |
| wdt_rst | input | 1 | Watchdog reset request |
| brownout | input | 1 | Brownout detect |
| cpu_hold | output | 1 | Freezes the program counter and fetches |
| periph_clk_en | output | 1 | Peripheral clock gate enable |
| core_clk_en | output | 1 | Core clock gate enable |
| osc_en | output | 1 | Crystal amplifier enable |
| rst_out | output | 1 | Qualified reset to the core |
| pwr_bits | output | 2 | Power-control bits: [1] stop, [0] idle |

## Verification
Errors in the mode register show up one cycle after the write or wake that exposed them, as a wrong gate pattern or wrong `pwr_bits`. A wrong wake or reset qualification shows as the block staying gated, or as `rst_out` pulsing, on the first cycle after the stimulus. A wrong settle counter shows only at the end of the interval: `cpu_hold` falls early or late relative to the `SETTLE_CYC` cycle count. The bench therefore checks both edges of that interval.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [1:0] {
    PM_RUN    = 2'd0,
    PM_IDLE   = 2'd1,
    PM_STOP   = 2'd2,
    PM_SETTLE = 2'd3
  } pm_state_e;

  typedef struct packed {
    logic cpu_hold;
    logic periph_clk_en;
    logic core_clk_en;
    logic osc_en;
  } pm_gate_t;

  function automatic pm_gate_t pm_gates(pm_state_e s);
    pm_gate_t g;
    case (s)
      PM_IDLE:   g = '{cpu_hold: 1'b1, periph_clk_en: 1'b1, core_clk_en: 1'b1, osc_en: 1'b1};
      PM_STOP:   g = '{cpu_hold: 1'b1, periph_clk_en: 1'b0, core_clk_en: 1'b0, osc_en: 1'b0};
      PM_SETTLE: g = '{cpu_hold: 1'b1, periph_clk_en: 1'b0, core_clk_en: 1'b0, osc_en: 1'b1};
      default:   g = '{cpu_hold: 1'b0, periph_clk_en: 1'b1, core_clk_en: 1'b1, osc_en: 1'b1};
    endcase
    return g;
  endfunction

endpackage

// File: rtl/pmc_reg_dec.sv
module pmc_reg_dec #(
  parameter int unsigned ADDR_W   = 8,
  parameter logic [7:0]  PCON_ADR = 8'h87
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        wdata,
  input  logic              cpu_live,
  output logic              go_idle,
  output logic              go_stop,
  output logic [1:0]        new_bits
);

  localparam logic [ADDR_W-1:0] HitAddr = ADDR_W'(PCON_ADR);

  logic hit;

  always_comb begin
    hit      = wr_en & cpu_live & (addr == HitAddr);
    go_stop  = hit & wdata[1];
    go_idle  = hit & wdata[0] & ~wdata[1];
    new_bits = wdata;
  end

endmodule

// File: rtl/pmc_src_qual.sv
module pmc_src_qual #(
  parameter int unsigned N_CLK_IRQ = 4,
  parameter int unsigned N_NC_IRQ  = 2
) (
  input  logic                 clocks_off,
  input  logic [N_CLK_IRQ-1:0] clk_irq_req,
  input  logic [N_CLK_IRQ-1:0] clk_irq_en,
  input  logic [N_NC_IRQ-1:0]  nc_irq_req,
  input  logic [N_NC_IRQ-1:0]  nc_irq_en,
  input  logic                 pf_req,
  input  logic                 pf_en,
  input  logic                 ref_en,
  input  logic                 ext_rst,
  input  logic                 wdt_rst,
  input  logic                 brownout,
  output logic                 idle_wake,
  output logic                 stop_wake,
  output logic                 qual_rst
);

  logic clk_any;
  logic nc_any;
  logic pf_live;

  always_comb begin
    clk_any   = |(clk_irq_req & clk_irq_en);
    nc_any    = |(nc_irq_req & nc_irq_en);
    pf_live   = pf_req & pf_en;
    idle_wake = clk_any | nc_any | pf_live;
    stop_wake = nc_any | (pf_live & ref_en);
    if (clocks_off) qual_rst = ext_rst | (brownout & ref_en);
    else            qual_rst = ext_rst | wdt_rst | brownout;
  end

endmodule

// File: rtl/pmc_settle_tmr.sv
module pmc_settle_tmr #(
  parameter int unsigned SETTLE_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic active,
  output logic done
);

  localparam int unsigned CntW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CntW-1:0] LoadVal = CntW'(SETTLE_CYC - 1);

  logic [CntW-1:0] cnt_q;
  logic [CntW-1:0] cnt_d;
  logic            cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (start) begin
      cnt_en = 1'b1;
      cnt_d  = LoadVal;
    end else if (active && cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
    done = active & (cnt_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R8: the count never leaves its loaded range
  a_r8_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LoadVal);

  // R8: a fresh start always loads the full interval
  a_r8_load_full: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> cnt_q == LoadVal);

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter logic [7:0]  PCON_ADR   = 8'h87,
  parameter int unsigned N_CLK_IRQ  = 4,
  parameter int unsigned N_NC_IRQ   = 2,
  parameter int unsigned SETTLE_CYC = 16
) (
  input  logic                 clk,
  input  logic                 por_n,
  input  logic                 pcon_wr,
  input  logic [ADDR_W-1:0]    pcon_addr,
  input  logic [1:0]           pcon_wdata,
  input  logic [N_CLK_IRQ-1:0] clk_irq_req,
  input  logic [N_CLK_IRQ-1:0] clk_irq_en,
  input  logic [N_NC_IRQ-1:0]  nc_irq_req,
  input  logic [N_NC_IRQ-1:0]  nc_irq_en,
  input  logic                 pf_req,
  input  logic                 pf_en,
  input  logic                 ref_en,
  input  logic                 ext_rst,
  input  logic                 wdt_rst,
  input  logic                 brownout,
  output logic                 cpu_hold,
  output logic                 periph_clk_en,
  output logic                 core_clk_en,
  output logic                 osc_en,
  output logic                 rst_out,
  output logic [1:0]           pwr_bits
);

  // power-on reset: asserted asynchronously, released through two flops
  logic [1:0] por_sync_q;
  logic       rst_n;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) por_sync_q <= 2'b00;
    else        por_sync_q <= {por_sync_q[0], 1'b1};
  end
  assign rst_n = por_sync_q[1];

  pm_state_e st_q, st_d;
  logic [1:0] bits_q, bits_d;
  logic       rst_q;
  logic       go_idle, go_stop;
  logic [1:0] new_bits;
  logic       idle_wake, stop_wake, qual_rst;
  logic       tmr_start, tmr_done;
  logic       clocks_off;
  pm_gate_t   gates;

  assign clocks_off = (st_q == PM_STOP) || (st_q == PM_SETTLE);

  pmc_reg_dec #(
    .ADDR_W   (ADDR_W),
    .PCON_ADR (PCON_ADR)
  ) u_dec (
    .wr_en    (pcon_wr),
    .addr     (pcon_addr),
    .wdata    (pcon_wdata),
    .cpu_live (st_q == PM_RUN),
    .go_idle  (go_idle),
    .go_stop  (go_stop),
    .new_bits (new_bits)
  );

  pmc_src_qual #(
    .N_CLK_IRQ (N_CLK_IRQ),
    .N_NC_IRQ  (N_NC_IRQ)
  ) u_qual (
    .clocks_off  (clocks_off),
    .clk_irq_req (clk_irq_req),
    .clk_irq_en  (clk_irq_en),
    .nc_irq_req  (nc_irq_req),
    .nc_irq_en   (nc_irq_en),
    .pf_req      (pf_req),
    .pf_en       (pf_en),
    .ref_en      (ref_en),
    .ext_rst     (ext_rst),
    .wdt_rst     (wdt_rst),
    .brownout    (brownout),
    .idle_wake   (idle_wake),
    .stop_wake   (stop_wake),
    .qual_rst    (qual_rst)
  );

  assign tmr_start = (st_q == PM_STOP) && stop_wake && !qual_rst;

  pmc_settle_tmr #(
    .SETTLE_CYC (SETTLE_CYC)
  ) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (tmr_start),
    .active (st_q == PM_SETTLE),
    .done   (tmr_done)
  );

  // next state: reset beats wake, wake beats write
  always_comb begin
    st_d   = st_q;
    bits_d = bits_q;
    if (qual_rst) begin
      st_d   = PM_RUN;
      bits_d = 2'b00;
    end else begin
      case (st_q)
        PM_RUN: begin
          if (go_stop) begin
            st_d   = PM_STOP;
            bits_d = new_bits;
          end else if (go_idle) begin
            st_d   = PM_IDLE;
            bits_d = new_bits;
          end
        end
        PM_IDLE: begin
          if (idle_wake) begin
            st_d   = PM_RUN;
            bits_d = 2'b00;
          end
        end
        PM_STOP: begin
          if (stop_wake) begin
            st_d   = PM_SETTLE;
            bits_d = 2'b00;
          end
        end
        PM_SETTLE: begin
          if (tmr_done) st_d = PM_RUN;
        end
        default: st_d = PM_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PM_RUN;
      bits_q <= 2'b00;
      rst_q  <= 1'b1;
    end else begin
      st_q   <= st_d;
      bits_q <= bits_d;
      rst_q  <= qual_rst;
    end
  end

  always_comb begin
    gates         = pm_gates(st_q);
    cpu_hold      = gates.cpu_hold;
    periph_clk_en = gates.periph_clk_en;
    core_clk_en   = gates.core_clk_en;
    osc_en        = gates.osc_en;
    rst_out       = rst_q;
    pwr_bits      = bits_q;
  end

  // R3: a stop write with either idle value gates everything next cycle
  a_r3_stop_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PM_RUN && pcon_wr && pcon_addr == ADDR_W'(PCON_ADR) && pcon_wdata[1] && !qual_rst)
      |=> (!core_clk_en && !osc_en && cpu_hold));

  // R4: an enabled idle wake frees the CPU and clears the bits
  a_r4_idle_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PM_IDLE && idle_wake && !qual_rst) |=> (!cpu_hold && pwr_bits == 2'b00));

  // R6: a watchdog reset alone does not disturb stop
  a_r6_wdt_in_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PM_STOP && wdt_rst && !ext_rst && !(brownout && ref_en) && !stop_wake)
      |=> (!rst_out && !osc_en));

  // R7: a qualified reset clears the bits and raises the reset output
  a_r7_rst_clears: assert property (@(posedge clk) disable iff (!rst_n)
    qual_rst |=> (rst_out && pwr_bits == 2'b00 && !cpu_hold));

  // R8: the CPU stays held while the settle interval runs
  a_r8_settle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PM_SETTLE && !tmr_done && !qual_rst) |=> (cpu_hold && osc_en && !core_clk_en));

  // R9: writes during idle do not change the bits
  a_r9_held_write: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PM_IDLE && !idle_wake && !qual_rst) |=> $stable(pwr_bits));

endmodule

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb;

  localparam int SETTLE = 16;

  logic       clk = 1'b0;
  logic       por_n;
  logic       pcon_wr;
  logic [7:0] pcon_addr;
  logic [1:0] pcon_wdata;
  logic [3:0] clk_irq_req, clk_irq_en;
  logic [1:0] nc_irq_req, nc_irq_en;
  logic       pf_req, pf_en, ref_en, ext_rst, wdt_rst, brownout;
  logic       cpu_hold, periph_clk_en, core_clk_en, osc_en, rst_out;
  logic [1:0] pwr_bits;

  int checks = 0;
  int errors = 0;

  // observed vector: {rst_out, pwr_bits[1:0], cpu_hold, periph, core, osc}
  localparam logic [6:0] V_RUN    = 7'b0_00_0111;
  localparam logic [6:0] V_RST    = 7'b1_00_0111;
  localparam logic [6:0] V_IDLE   = 7'b0_01_1111;
  localparam logic [6:0] V_STOP10 = 7'b0_10_1000;
  localparam logic [6:0] V_STOP11 = 7'b0_11_1000;
  localparam logic [6:0] V_SETTLE = 7'b0_00_1001;

  always #10 clk = ~clk;

  pwr_mode_ctrl #(.SETTLE_CYC(SETTLE)) u_dut (
    .clk(clk), .por_n(por_n), .pcon_wr(pcon_wr), .pcon_addr(pcon_addr),
    .pcon_wdata(pcon_wdata), .clk_irq_req(clk_irq_req), .clk_irq_en(clk_irq_en),
    .nc_irq_req(nc_irq_req), .nc_irq_en(nc_irq_en), .pf_req(pf_req), .pf_en(pf_en),
    .ref_en(ref_en), .ext_rst(ext_rst), .wdt_rst(wdt_rst), .brownout(brownout),
    .cpu_hold(cpu_hold), .periph_clk_en(periph_clk_en), .core_clk_en(core_clk_en),
    .osc_en(osc_en), .rst_out(rst_out), .pwr_bits(pwr_bits)
  );

  function automatic logic [6:0] obs();
    return {rst_out, pwr_bits, cpu_hold, periph_clk_en, core_clk_en, osc_en};
  endfunction

  task automatic check(input string req, input logic [6:0] exp);
    checks++;
    if (obs() !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, obs(), exp, $time);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [1:0] d);
    pcon_wr = 1'b1; pcon_addr = a; pcon_wdata = d;
    step();
    pcon_wr = 1'b0;
  endtask

  task automatic quiet();
    clk_irq_req = '0; nc_irq_req = '0; pf_req = 1'b0;
    ext_rst = 1'b0; wdt_rst = 1'b0; brownout = 1'b0;
  endtask

  task automatic t_r1_reset_state();
    por_n = 1'b0;
    step(3);
    check("R1 reset out during por", V_RST);
    por_n = 1'b1;
    step(4);
    check("R1 run after por", V_RUN);
  endtask

  task automatic t_r2_idle_and_miss();
    wr(8'h86, 2'b01);
    check("R2 other address ignored", V_RUN);
    wr(8'h87, 2'b01);
    check("R2 idle entry", V_IDLE);
    wr(8'h87, 2'b10);
    check("R9 write in idle ignored", V_IDLE);
    clk_irq_en = 4'b0000; clk_irq_req = 4'b0100;
    step();
    check("R4 disabled clocked irq ignored in idle", V_IDLE);
    clk_irq_en = 4'b0100;
    step();
    check("R4 clocked irq exits idle", V_RUN);
    quiet();
    wr(8'h87, 2'b01);
    pf_req = 1'b1;
    step();
    check("R4 power-fail irq exits idle", V_RUN);
    quiet();
  endtask

  task automatic t_r3_r5_r6_stop_ignores();
    wr(8'h87, 2'b11);
    check("R3 stop wins over idle", V_STOP11);
    clk_irq_req = 4'b0100;
    step();
    check("R5 clocked irq ignored in stop", V_STOP11);
    quiet();
    nc_irq_en = 2'b00; nc_irq_req = 2'b01;
    step();
    check("R5 disabled nc irq ignored in stop", V_STOP11);
    quiet();
    ref_en = 1'b0; pf_req = 1'b1;
    step();
    check("R5 power-fail without reference ignored", V_STOP11);
    quiet();
    wdt_rst = 1'b1;
    step();
    check("R6 watchdog ignored in stop", V_STOP11);
    quiet();
    brownout = 1'b1;
    step();
    check("R6 brownout ignored without reference", V_STOP11);
    quiet();
    wr(8'h87, 2'b01);
    check("R9 write in stop ignored", V_STOP11);
  endtask

  task automatic t_r8_settle_nc();
    nc_irq_en = 2'b10; nc_irq_req = 2'b10;
    step();
    nc_irq_req = 2'b00;
    check("R8 settle begins after nc wake", V_SETTLE);
    step(SETTLE - 1);
    check("R8 still held at end of interval", V_SETTLE);
    step();
    check("R8 run after settle interval", V_RUN);
  endtask

  task automatic t_r7_resets();
    wr(8'h87, 2'b10);
    check("R3 stop entry", V_STOP10);
    ref_en = 1'b1; pf_req = 1'b1;
    step();
    pf_req = 1'b0;
    check("R5 power-fail with reference wakes stop", V_SETTLE);
    step(3);
    ext_rst = 1'b1;
    step();
    check("R7 pin reset during settle", V_RST);
    step(2);
    check("R7 reset held while pin high", V_RST);
    ext_rst = 1'b0;
    step();
    check("R7 reset releases one cycle later", V_RUN);
    wr(8'h87, 2'b10);
    brownout = 1'b1;
    step();
    check("R7 brownout with reference resets stop", V_RST);
    brownout = 1'b0;
    step();
    check("R7 run after brownout release", V_RUN);
    wr(8'h87, 2'b01);
    wdt_rst = 1'b1;
    step();
    check("R7 watchdog resets idle", V_RST);
    wdt_rst = 1'b0;
    step();
    check("R7 run after watchdog release", V_RUN);
    ref_en = 1'b0; brownout = 1'b1;
    step();
    check("R7 brownout resets run", V_RST);
    quiet();
    step();
    check("R7 run after brownout in run", V_RUN);
  endtask

  initial begin
    por_n = 1'b0; pcon_wr = 1'b0; pcon_addr = '0; pcon_wdata = '0;
    clk_irq_en = '0; nc_irq_en = '0; pf_en = 1'b1; ref_en = 1'b0;
    quiet();
    t_r1_reset_state();
    t_r2_idle_and_miss();
    t_r3_r5_r6_stop_ignores();
    t_r8_settle_nc();
    t_r7_resets();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule